// File: doc/BRIEF.md
# Extended Match-Control Timer

This block holds eight match channels, numbered 4 to 11. Each channel has a 32-bit counter, a 32-bit match value and a control word. The control word picks which of five tick-enable inputs advances the counter. It also sets whether the channel compares against its own counter or against the counter of its group leader, whether a match zeroes the channel's counter, and whether the channel keeps matching after its first event or stops after one. The tick-enable inputs come from outside the block, which generates no clocks itself.

A match event sets a status bit if the interrupt enable for that channel is set. Status bits are cleared by writing ones to them. One interrupt output stays high while any status bit is set. Reading counter 9 or counter 11 can also capture counter 8 or counter 10 into a snapshot register, so software can sample a pair of counters together.

Top module: `xmt_timer`

## Requirements
- R1: After reset, every counter, match value, control word, the snapshot register, the status bits and the enables read as zero, and `irq_o` is low.
- R2: The select field, control bits [2:0], picks the tick input. Code 1 uses `tick_i[0]`, 2 uses `tick_i[1]`, 3 uses `tick_i[2]`, 4 uses `tick_i[3]` and 5 uses `tick_i[4]`. Codes 0, 6 and 7 select no tick.
- R3: A running counter adds one on each clock cycle in which its selected tick is high, and it wraps from all ones to zero. A counter write in the same cycle as a tick takes priority.
- R4: With control bit 7 set, a channel compares against its own counter. With bit 7 clear, channels 4–7 compare against counter 4, channels 8–9 against counter 8, and channels 10–11 against counter 10.
- R5: The counters of channels 4, 8 and 10 always run from their select field. Any other channel with bit 7 clear has its own counter stopped. On channels 8–11, control bit 8 forces the selection to no tick.
- R6: Control words of channels 4–7 keep bits [7:0] only. Control words of channels 8–11 keep bits [9:0].
- R7: A match event occurs in the cycle where a tick moves the compared counter onto the channel's match value.
- R8: With control bit 3 set, a match event loads zero into the channel's own counter instead of the matched value.
- R9: With control bit 6 clear, a channel gives one match event and then stays quiet until its match value or its control word is written again. With bit 6 set, it matches every time.
- R10: A match event sets status bit 4+n for channel n (n = 0 to 7) only when enable bit 4+n is set.
- R11: Writing the status register clears exactly the status bits written as one. Bits written as zero, and bits that are not set, are left unchanged.
- R12: `irq_o` is high while any status bit is set and goes low once all of them are clear.
- R13: A read strobe on counter 9 whose control has bit 9 set loads counter 8 into the snapshot register. A read strobe on counter 11 whose control has bit 9 set loads counter 10. No other access changes the snapshot register.
- R14: Address map: counters at 0x40 + 4n, match values at 0x80 + 4n, control words at 0xC0 + 4n, snapshot at 0x20, status at 0x24 and enables at 0x28, each using bits [11:4]. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 5 | Tick enables: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (used by the snapshot capture) |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt for channels 4–11 |

## Verification
The assertions assume that register accesses use aligned addresses and that a write strobe and a read strobe never come in the same cycle. They also assume that a tick input is high for whole clock cycles and counts once per cycle it is high. The stimulus drives every access on the falling edge and keeps reads and writes in separate cycles. It changes the tick inputs only between accesses, so every status change and snapshot change can be traced to one match event or one access.

// File: rtl/xmt_pkg.sv
package xmt_pkg;
  localparam int NCH = 8;
  localparam int CW  = 32;
  localparam int DW  = 32;
  localparam int AW  = 8;
  localparam int NTK = 5;
  localparam int CTLW = 10;
  localparam int STAT_LSB = 4;

  localparam logic [AW-1:0] A_SNAP = 8'h20;
  localparam logic [AW-1:0] A_STAT = 8'h24;
  localparam logic [AW-1:0] A_IEN  = 8'h28;
  localparam logic [2:0] WIN_CNT = 3'b010;
  localparam logic [2:0] WIN_MAT = 3'b100;
  localparam logic [2:0] WIN_CTL = 3'b110;

  typedef struct packed {
    logic       snap_en;
    logic       force_off;
    logic       own_cnt;
    logic       periodic;
    logic [1:0] spare;
    logic       zero_on_hit;
    logic [2:0] clk_sel;
  } xmt_ctrl_t;

  // local channel index 0..7 stands for channel 4..11
  function automatic int leader_of(input int ch);
    if (ch < 4) return 0;
    else if (ch < 6) return 4;
    else return 6;
  endfunction

  function automatic logic is_leader(input int ch);
    return (ch == 0) || (ch == 4) || (ch == 6);
  endfunction

  function automatic logic [CTLW-1:0] ctl_mask(input int ch);
    return (ch < 4) ? 10'h0FF : 10'h3FF;
  endfunction

  function automatic logic pick_tick(input logic [2:0] sel, input logic [NTK-1:0] tk);
    case (sel)
      3'd1: return tk[0];
      3'd2: return tk[1];
      3'd3: return tk[2];
      3'd4: return tk[3];
      3'd5: return tk[4];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic runs(input int ch, input xmt_ctrl_t c);
    return (c.own_cnt || is_leader(ch)) && !((ch >= 4) && c.force_off);
  endfunction

  function automatic logic lands_on(input logic [CW-1:0] cnt, input logic [CW-1:0] mat);
    return CW'(cnt + 1'b1) == mat;
  endfunction
endpackage

// File: rtl/xmt_tick_sel.sv
module xmt_tick_sel
  import xmt_pkg::*;
#(
  parameter int CH = 0
) (
  input  xmt_ctrl_t      ctl_i,
  input  logic [NTK-1:0] tick_i,
  output logic           tick_o
);
  always_comb tick_o = runs(CH, ctl_i) && pick_tick(ctl_i.clk_sel, tick_i);
endmodule

// File: rtl/xmt_channel.sv
module xmt_channel
  import xmt_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NTK-1:0] tick_i,
  input  logic           cnt_we_i,
  input  logic           mat_we_i,
  input  logic           ctl_we_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [CW-1:0]  cmp_cnt_i,
  input  logic           cmp_tick_i,
  output logic [CW-1:0]  cnt_o,
  output logic [CW-1:0]  mat_o,
  output xmt_ctrl_t      ctl_o,
  output logic           own_tick_o,
  output logic           hit_o,
  output logic           armed_o
);
  xmt_tick_sel #(.CH(CH)) u_sel (
    .ctl_i  (ctl_o),
    .tick_i (tick_i),
    .tick_o (own_tick_o)
  );

  always_comb hit_o = armed_o && cmp_tick_i && lands_on(cmp_cnt_i, mat_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o   <= '0;
      mat_o   <= '0;
      ctl_o   <= '0;
      armed_o <= 1'b1;
    end else begin
      if (cnt_we_i)                      cnt_o <= wdata_i[CW-1:0];
      else if (hit_o && ctl_o.zero_on_hit) cnt_o <= '0;
      else if (own_tick_o)               cnt_o <= cnt_o + 1'b1;

      if (mat_we_i) mat_o <= wdata_i[CW-1:0];
      if (ctl_we_i) ctl_o <= xmt_ctrl_t'(wdata_i[CTLW-1:0] & ctl_mask(CH));

      if (ctl_we_i || mat_we_i)          armed_o <= 1'b1;
      else if (hit_o && !ctl_o.periodic) armed_o <= 1'b0;
    end
  end
endmodule

// File: rtl/xmt_status.sv
module xmt_status
  import xmt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stat_we_i,
  input  logic           ien_we_i,
  input  logic [NCH-1:0] wbits_i,
  input  logic [NCH-1:0] hit_i,
  output logic [NCH-1:0] stat_o,
  output logic [NCH-1:0] ien_o,
  output logic           irq_o
);
  logic [NCH-1:0] clr;
  always_comb clr = stat_we_i ? (wbits_i & stat_o) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_o <= '0;
      ien_o  <= '0;
    end else begin
      stat_o <= (stat_o & ~clr) | (hit_i & ien_o);
      if (ien_we_i) ien_o <= wbits_i;
    end
  end

  always_comb irq_o = |stat_o;
endmodule

// File: rtl/xmt_timer.sv
module xmt_timer
  import xmt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [4:0]     tick_i,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic [7:0]     addr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  output logic           irq_o
);
  localparam int IW = $clog2(NCH);

  logic [CW-1:0]  cnt [NCH];
  logic [CW-1:0]  mat [NCH];
  xmt_ctrl_t      ctl [NCH];
  logic [NCH-1:0] own_tick, ch_hit, ch_armed, ch_periodic, ch_rearm;
  logic [NCH-1:0] cnt_we, mat_we, ctl_we;
  logic [NCH-1:0] stat, ien;
  logic [CW-1:0]  snap;

  logic [2:0]    win;
  logic [IW-1:0] idx;
  logic          aligned;
  always_comb begin
    win     = addr_i[7:5];
    idx     = addr_i[2 +: IW];
    aligned = (addr_i[1:0] == 2'b00);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int LEAD = leader_of(g);
    logic          sel_here;
    logic [CW-1:0] cmp_cnt;
    logic          cmp_tick;

    always_comb begin
      sel_here   = aligned && (idx == IW'(g));
      cnt_we[g]  = wr_en_i && sel_here && (win == WIN_CNT);
      mat_we[g]  = wr_en_i && sel_here && (win == WIN_MAT);
      ctl_we[g]  = wr_en_i && sel_here && (win == WIN_CTL);
      cmp_cnt    = ctl[g].own_cnt ? cnt[g] : cnt[LEAD];
      cmp_tick   = ctl[g].own_cnt ? own_tick[g] : own_tick[LEAD];
      ch_periodic[g] = ctl[g].periodic;
      ch_rearm[g]    = mat_we[g] || ctl_we[g];
    end

    xmt_channel #(.CH(g)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .cnt_we_i   (cnt_we[g]),
      .mat_we_i   (mat_we[g]),
      .ctl_we_i   (ctl_we[g]),
      .wdata_i    (wdata_i),
      .cmp_cnt_i  (cmp_cnt),
      .cmp_tick_i (cmp_tick),
      .cnt_o      (cnt[g]),
      .mat_o      (mat[g]),
      .ctl_o      (ctl[g]),
      .own_tick_o (own_tick[g]),
      .hit_o      (ch_hit[g]),
      .armed_o    (ch_armed[g])
    );
  end

  xmt_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_we_i (wr_en_i && (addr_i == A_STAT)),
    .ien_we_i  (wr_en_i && (addr_i == A_IEN)),
    .wbits_i   (wdata_i[STAT_LSB +: NCH]),
    .hit_i     (ch_hit),
    .stat_o    (stat),
    .ien_o     (ien),
    .irq_o     (irq_o)
  );

  // snapshot: reading counter 9 grabs counter 8, counter 11 grabs counter 10
  logic cap_lo, cap_hi;
  always_comb begin
    cap_lo = rd_en_i && aligned && (win == WIN_CNT) && (idx == IW'(5)) && ctl[5].snap_en;
    cap_hi = rd_en_i && aligned && (win == WIN_CNT) && (idx == IW'(7)) && ctl[7].snap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap <= '0;
    else if (cap_lo) snap <= cnt[4];
    else if (cap_hi) snap <= cnt[6];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_SNAP)      rdata_o = DW'(snap);
    else if (addr_i == A_STAT) rdata_o[STAT_LSB +: NCH] = stat;
    else if (addr_i == A_IEN)  rdata_o[STAT_LSB +: NCH] = ien;
    else if (aligned) begin
      case (win)
        WIN_CNT: rdata_o = DW'(cnt[idx]);
        WIN_MAT: rdata_o = DW'(mat[idx]);
        WIN_CTL: rdata_o = DW'(ctl[idx]);
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/xmt_timer_chk.sv
module xmt_timer_chk
  import xmt_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en_i,
  input logic           rd_en_i,
  input logic [7:0]     addr_i,
  input logic [NCH-1:0] ch_hit,
  input logic [NCH-1:0] ch_armed,
  input logic [NCH-1:0] ch_periodic,
  input logic [NCH-1:0] ch_rearm,
  input logic [NCH-1:0] stat,
  input logic [NCH-1:0] ien,
  input logic [CW-1:0]  snap,
  input logic           irq_o
);
  a_r12_event_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_hit & ien)) |=> irq_o);

  a_r10_no_set_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(ch_hit & ien)) |=> ((stat & ~$past(stat)) == '0));

  a_r11_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && (addr_i == A_STAT)) |=> ((~stat & $past(stat)) == '0));

  a_r9_oneshot_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ch_hit & ~ch_periodic & ~ch_rearm)) |=> ((ch_armed & $past(ch_hit & ~ch_periodic & ~ch_rearm)) == '0));

  a_r13_snapshot_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_i && ((addr_i == 8'h54) || (addr_i == 8'h5C))) |=> $stable(snap));
endmodule

bind xmt_timer xmt_timer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .addr_i      (addr_i),
  .ch_hit      (ch_hit),
  .ch_armed    (ch_armed),
  .ch_periodic (ch_periodic),
  .ch_rearm    (ch_rearm),
  .stat        (stat),
  .ien         (ien),
  .snap        (snap),
  .irq_o       (irq_o)
);

// File: tb/tb_xmt_timer.sv
module tb_xmt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  tick = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_run = 0, n_fail = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  xmt_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {sel[15:13], ticks[12:8], expected increment[7:0]}
  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    {3'd1, 5'b00001, 8'd1}, {3'd1, 5'b11110, 8'd0}, {3'd2, 5'b00010, 8'd1},
    {3'd2, 5'b11101, 8'd0}, {3'd3, 5'b00100, 8'd1}, {3'd4, 5'b01000, 8'd1},
    {3'd4, 5'b10111, 8'd0}, {3'd5, 5'b10000, 8'd1}, {3'd0, 5'b11111, 8'd0},
    {3'd6, 5'b11111, 8'd0}, {3'd7, 5'b11111, 8'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tk(input logic [4:0] pat, input int n);
    @(negedge clk); tick = pat;
    repeat (n) @(negedge clk);
    tick = '0;
  endtask

  function automatic logic [7:0] a_cnt(input int ch); return 8'h40 + 8'(4 * (ch - 4)); endfunction
  function automatic logic [7:0] a_mat(input int ch); return 8'h80 + 8'(4 * (ch - 4)); endfunction
  function automatic logic [7:0] a_ctl(input int ch); return 8'hC0 + 8'(4 * (ch - 4)); endfunction
  function automatic logic [31:0] sbit(input int ch); return 32'h1 << ch; endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    peek(a_cnt(4), v);  chk("R1 cnt4", v, 0);
    peek(a_mat(7), v);  chk("R1 mat7", v, 0);
    peek(a_ctl(11), v); chk("R1 ctl11", v, 0);
    peek(8'h20, v);     chk("R1 snap", v, 0);
    peek(8'h24, v);     chk("R1 stat", v, 0);
    peek(8'h28, v);     chk("R1 ien", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 clock select table
    for (int i = 0; i < NV; i++) begin
      wr(a_ctl(4), {29'b0, VEC[i][15:13]});
      wr(a_cnt(4), 32'h0);
      tk(VEC[i][12:8], 1);
      peek(a_cnt(4), v);
      chk($sformatf("R2 vec%0d", i), v, {24'b0, VEC[i][7:0]});
    end

    // R6 control widths
    wr(a_ctl(5), 32'hFFFF_FFFF); peek(a_ctl(5), v); chk("R6 ctl5 8 bits", v, 32'h0FF);
    wr(a_ctl(9), 32'hFFFF_FFFF); peek(a_ctl(9), v); chk("R6 ctl9 10 bits", v, 32'h3FF);
    wr(a_ctl(5), 0); wr(a_ctl(9), 0);

    // R3 wrap and write priority
    wr(a_ctl(4), 32'h1); wr(a_cnt(4), 32'hFFFF_FFFF);
    tk(5'b00001, 1); peek(a_cnt(4), v); chk("R3 wrap", v, 0);
    tk(5'b00001, 3); peek(a_cnt(4), v); chk("R3 three ticks", v, 3);
    @(negedge clk); addr = a_cnt(4); wdata = 32'h10; wr_en = 1'b1; tick = 5'b00001;
    @(negedge clk); wr_en = 1'b0; tick = '0;
    peek(a_cnt(4), v); chk("R3 write wins", v, 32'h10);

    // R4/R7 channel 5 shares counter 4; R5 its own counter stopped
    wr(a_ctl(4), 32'h3); wr(a_cnt(4), 0);
    wr(8'h28, sbit(5)); wr(a_mat(5), 3); wr(a_ctl(5), 32'h3);
    tk(5'b00100, 2); peek(8'h24, v); chk("R7 no event before match", v, 0);
    tk(5'b00100, 1); peek(8'h24, v); chk("R4 shared match ch5", v, sbit(5));
    chk("R12 irq high", {31'b0, irq}, 1);
    peek(a_cnt(5), v); chk("R5 ch5 own counter stopped", v, 0);
    wr(8'h24, sbit(5)); peek(8'h24, v); chk("R11 cleared", v, 0);
    chk("R12 irq low", {31'b0, irq}, 0);

    // R4 group 8/9
    wr(a_ctl(8), 32'h1); wr(a_cnt(8), 0); wr(a_mat(9), 2); wr(a_ctl(9), 0);
    wr(8'h28, sbit(9));
    tk(5'b00001, 2); peek(8'h24, v); chk("R4 shared match ch9", v, sbit(9));
    wr(8'h24, sbit(9));

    // R5 bit 8 forces no tick
    wr(a_ctl(10), 32'h101); wr(a_cnt(10), 0);
    tk(5'b00001, 3); peek(a_cnt(10), v); chk("R5 force off ch10", v, 0);

    // R8 reset-on-match, R9 one-shot
    wr(a_ctl(6), 32'h89); wr(a_mat(6), 4); wr(a_cnt(6), 0); wr(8'h28, sbit(6));
    tk(5'b00001, 4);
    peek(a_cnt(6), v); chk("R8 zero on match", v, 0);
    peek(8'h24, v);    chk("R8 event ch6", v, sbit(6));
    tk(5'b00001, 2); peek(a_cnt(6), v); chk("R8 counts on", v, 2);
    wr(8'h24, sbit(6));
    tk(5'b00001, 2);
    peek(8'h24, v);    chk("R9 one-shot quiet", v, 0);
    peek(a_cnt(6), v); chk("R9 no reset when disarmed", v, 4);

    // R9 periodic
    wr(a_ctl(7), 32'hC9); wr(a_mat(7), 2); wr(a_cnt(7), 0); wr(8'h28, sbit(7));
    tk(5'b00001, 2); peek(8'h24, v); chk("R9 periodic first", v, sbit(7));
    wr(8'h24, sbit(7));
    tk(5'b00001, 2); peek(8'h24, v); chk("R9 periodic again", v, sbit(7));
    wr(8'h24, sbit(7));

    // R10 no status without enable
    wr(8'h28, 0); wr(a_ctl(6), 32'h89); wr(a_cnt(6), 0);
    tk(5'b00001, 4);
    peek(8'h24, v);    chk("R10 disabled status", v, 0);
    chk("R10 irq low", {31'b0, irq}, 0);
    peek(a_cnt(6), v); chk("R10 match still occurred", v, 0);

    // R11 partial clear
    wr(8'h28, sbit(6) | sbit(7));
    wr(a_ctl(6), 32'h89); wr(a_cnt(6), 0); wr(a_ctl(7), 32'hC9); wr(a_cnt(7), 0);
    tk(5'b00001, 4);
    peek(8'h24, v); chk("R11 both set", v, sbit(6) | sbit(7));
    wr(8'h24, sbit(6) | 32'hF); peek(8'h24, v); chk("R11 partial clear", v, sbit(7));
    chk("R12 irq stays", {31'b0, irq}, 1);
    wr(8'h24, sbit(7)); chk("R12 irq drops", {31'b0, irq}, 0);
    wr(8'h28, 0);

    // R13 snapshot
    wr(a_ctl(8), 0); wr(a_cnt(8), 32'h1234); wr(a_ctl(9), 32'h200);
    rd(a_cnt(9)); peek(8'h20, v); chk("R13 snap from cnt8", v, 32'h1234);
    wr(a_ctl(10), 0); wr(a_cnt(10), 32'h55); wr(a_ctl(11), 0);
    rd(a_cnt(11)); peek(8'h20, v); chk("R13 no capture bit9 clear", v, 32'h1234);
    wr(a_ctl(11), 32'h200);
    peek(a_cnt(11), v); @(negedge clk); peek(8'h20, v); chk("R13 no capture without strobe", v, 32'h1234);
    rd(a_cnt(11)); peek(8'h20, v); chk("R13 snap from cnt10", v, 32'h55);

    // R14 address map
    wr(a_mat(11), 32'hCAFE_0011); peek(8'h9C, v); chk("R14 mat11", v, 32'hCAFE_0011);
    peek(8'h30, v); chk("R14 unmapped", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule